// File: doc/BRIEF.md
# Initialization Fetch Responder

During its first start-up after reset, a local I/O processor reads a handful of fixed locations at the very top of its 20-bit address space. This block answers those reads from board straps, not from memory. It captures the address from a multiplexed address/data bus while the latch strobe is high. When a read then targets one of the reserved locations, it drives the matching configuration word onto the bus and pulses a transfer acknowledge.

The reserved locations carry three kinds of data:
- a flag giving the width of the host memory bus;
- words of zeros;
- the wake-up address switch setting.

The processor shifts the switch setting left by four to form the 20-bit address of its first communication block. The block also presents that address directly on an output. Reads elsewhere, and all writes, get no response, so other responders on the bus can serve them.

Top module: `init_fetch_resp`

## Requirements
- R1: After reset, `ad_oe` and `xack` are 0 and `ad_out` is 0.
- R2: The 20-bit address `{a_hi, ad_in}` is captured on a clock edge where `ale` is 1. Later changes on `ad_in` while `ale` is 0 do not alter the decode.
- R3: A read of 20'hFFFF6 returns `{15'b0, narrow_bus}`. Bit 0 is 0 for a 16-bit host memory and 1 for an 8-bit host memory.
- R4: Reads of 20'hFFFF8 and 20'hFFFF9 return 16'h0000 with `ad_oe` = 1.
- R5: A read of 20'hFFFFA returns `wake_sw`. A read of the odd byte 20'hFFFFB returns `wake_sw[15:8]` on both byte lanes.
- R6: For a decoded read, `xack` is 1 for exactly one clock, starting on the first clock edge that samples `rd_n` = 0. It stays 0 for the rest of that strobe.
- R7: `ad_oe` is 1 only from that same edge until the first edge that samples `rd_n` = 1. Whenever `ad_oe` is 0, `ad_out` is 0.
- R8: A read of any other address, including 20'hFFFF7, 20'hFFFFC and 20'h0FFF6, leaves `ad_oe` and `xack` at 0.
- R9: A write (`wr_n` = 0) to a decoded address leaves `ad_oe` and `xack` at 0.
- R10: `wake_blk_addr` equals `{wake_sw, 4'b0000}` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch strobe, active high |
| a_hi | input | 4 | Address bits 19:16 |
| ad_in | input | 16 | Multiplexed address/data lines, address bits 15:0 |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| narrow_bus | input | 1 | Strap: 1 = 8-bit host memory, 0 = 16-bit |
| wake_sw | input | 16 | Wake-up address switch setting |
| ad_out | output | 16 | Data driven during a decoded read |
| ad_oe | output | 1 | Output enable for `ad_out`; bus high-impedance when 0 |
| xack | output | 1 | Transfer acknowledge pulse |
| wake_blk_addr | output | 20 | Wake-up block address |

## Verification
A read strobe can be released on the same edge at which the next address is latched. The bench provokes this by raising `rd_n` and `ale` together at one negative edge. After the following edge, it requires `ad_oe` and `xack` to be low. The next read must then return the word for the new address with a fresh single acknowledge, and must not carry over the previous word.

// File: rtl/init_fetch_resp.sv
module init_fetch_resp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ale,
  input  logic [3:0]  a_hi,
  input  logic [15:0] ad_in,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        narrow_bus,
  input  logic [15:0] wake_sw,
  output logic [15:0] ad_out,
  output logic        ad_oe,
  output logic        xack,
  output logic [19:0] wake_blk_addr
);

  logic [19:0] addr_q;
  logic        hit;
  logic [15:0] word;
  logic        served;
  logic        rd_go;

  assign wake_blk_addr = {wake_sw, 4'b0000};
  assign rd_go = !rd_n && wr_n && !ale;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (ale) addr_q <= {a_hi, ad_in};
  end

  always_comb begin
    hit  = 1'b1;
    word = '0;
    case (addr_q)
      20'hFFFF6: word = {15'b0, narrow_bus};
      20'hFFFF8,
      20'hFFFF9: word = '0;
      20'hFFFFA: word = wake_sw;
      20'hFFFFB: word = {wake_sw[15:8], wake_sw[15:8]};
      default:   hit  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rd_go || !hit) begin
      ad_oe  <= 1'b0;
      ad_out <= '0;
      xack   <= 1'b0;
      served <= 1'b0;
    end else begin
      ad_oe  <= 1'b1;
      ad_out <= word;
      xack   <= !served;
      served <= 1'b1;
    end
  end

  a_r6_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xack |=> !xack);
  a_r6_ack_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    xack |-> ad_oe);
  a_r7_oe_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(!rd_n));
  a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> ad_out == 16'h0000);
  a_r9_no_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(wr_n));
  a_r10_block_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wake_blk_addr[3:0] == 4'h0 && wake_blk_addr[19:4] == wake_sw);

endmodule

// File: tb/init_fetch_resp_tb_top.sv
module init_fetch_resp_tb_top;
  logic clk = 0, rst_n = 0, ale = 0, rd_n = 1, wr_n = 1, narrow_bus = 0;
  logic [3:0] a_hi = 0;
  logic [15:0] ad_in = 0, wake_sw = 16'h1234;
  logic [15:0] ad_out;
  logic ad_oe, xack;
  logic [19:0] wake_blk_addr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  init_fetch_resp dut_i (.clk, .rst_n, .ale, .a_hi, .ad_in, .rd_n, .wr_n,
    .narrow_bus, .wake_sw, .ad_out, .ad_oe, .xack, .wake_blk_addr);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic done_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 oe", ad_oe, 0); chk("R1 xack", xack, 0); chk("R1 data", ad_out, 0);
    rst_n = 1;
  endtask

  task automatic rd_cycle(input logic [19:0] a, input logic hit, input logic [15:0] exp, input string rq);
    @(negedge clk) ale = 1; {a_hi, ad_in} = a; rd_n = 1;
    @(negedge clk) ale = 0; ad_in = 16'hBEEF; rd_n = 0;
    @(negedge clk);
    chk({rq, " oe"}, ad_oe, hit); chk({"R6 ", rq, " xack"}, xack, hit);
    chk({rq, " data"}, ad_out, hit ? exp : 16'h0);
    @(negedge clk);
    chk({"R6 ", rq, " xack off"}, xack, 0); chk({"R7 ", rq, " oe hold"}, ad_oe, hit);
    rd_n = 1;
    @(negedge clk);
    chk({"R7 ", rq, " oe off"}, ad_oe, 0); chk({"R7 ", rq, " data off"}, ad_out, 0);
  endtask

  task automatic t_write(input logic [19:0] a);
    @(negedge clk) ale = 1; {a_hi, ad_in} = a;
    @(negedge clk) ale = 0; wr_n = 0;
    repeat (2) begin
      @(negedge clk);
      chk("R9 oe", ad_oe, 0); chk("R9 xack", xack, 0);
    end
    wr_n = 1;
  endtask

  task automatic t_overlap();
    @(negedge clk) ale = 1; {a_hi, ad_in} = 20'hFFFFA; rd_n = 1;
    @(negedge clk) ale = 0; rd_n = 0;
    @(negedge clk) chk("R5 first word", ad_out, wake_sw);
    ale = 1; rd_n = 1; {a_hi, ad_in} = 20'hFFFF9;
    @(negedge clk);
    chk("R7 overlap oe", ad_oe, 0); chk("R6 overlap xack", xack, 0);
    ale = 0; rd_n = 0; ad_in = 16'h5555;
    @(negedge clk);
    chk("R2 overlap new word", ad_out, 0); chk("R6 overlap ack", xack, 1);
    chk("R4 overlap oe", ad_oe, 1);
    @(negedge clk) rd_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    done_run();
  end

  initial begin
    t_reset();
    chk("R10 blk", wake_blk_addr, 20'h12340);
    narrow_bus = 0; rd_cycle(20'hFFFF6, 1, 16'h0000, "R3 16bit");
    narrow_bus = 1; rd_cycle(20'hFFFF6, 1, 16'h0001, "R3 8bit");
    rd_cycle(20'hFFFF8, 1, 16'h0000, "R4 F8");
    rd_cycle(20'hFFFF9, 1, 16'h0000, "R4 F9");
    rd_cycle(20'hFFFFA, 1, 16'h1234, "R5 FA R2");
    rd_cycle(20'hFFFFB, 1, 16'h1212, "R5 FB");
    wake_sw = 16'hA5C3; #1;
    chk("R10 blk2", wake_blk_addr, 20'hA5C30);
    rd_cycle(20'hFFFFA, 1, 16'hA5C3, "R5 FA2");
    rd_cycle(20'hFFFF7, 0, 16'h0, "R8 F7");
    rd_cycle(20'hFFFFC, 0, 16'h0, "R8 FC");
    rd_cycle(20'h0FFF6, 0, 16'h0, "R8 low");
    t_write(20'hFFFFA);
    t_write(20'hFFFF6);
    t_overlap();
    done_run();
  end
endmodule